// File: doc/BRIEF.md
# I2C Slave Byte Engine with Host-Controlled Clock Stretching

This block is a 7-bit-address I2C target that lives entirely in one synchronous clock domain. SCL and SDA are brought in through synchronizer flops. START and STOP conditions and the SCL edges are derived from the synchronized levels. The engine compares each address byte with a programmable address and then receives or transmits whole bytes. It does not drive the pads. It raises `scl_oe` or `sda_oe` when the matching line must be pulled low, and the pad logic outside the block performs the wired-AND.

In receive mode each completed byte moves into a one-entry buffer. The buffer is presented to the host as a valid/ready stream: `rx_valid` rises when a byte lands, and `rx_data` holds steady until the host accepts it with `rx_ready`. The engine does not wait for the host. If a new byte finishes while the previous one is still unaccepted, that is back-pressure the bus cannot honour: the new byte is dropped, an overflow flag is raised and the byte is not acknowledged.

In transmit mode the engine holds SCL low after each acknowledged byte. It keeps it low until the host has written the next byte and pulsed the clock-release input. A per-byte interrupt flag tells the host that it needs to act.

Top module: `i2c_slave_engine`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `rx_valid`, `irq`, `ovf` and `rw_flag` are all 0.
- R2: A STOP (SDA rising while SCL is high) at any point returns the engine to idle, drops `scl_oe` and `sda_oe` and cancels a pending stretch. After a STOP, bus activity is ignored until a START (SDA falling while SCL is high).
- R3: In the first byte after a START, bits 7:1 (sent first) are the address and bit 0 is the direction (1 = master reads). When bits 7:1 equal `own_addr`, the engine drives ACK (`sda_oe`=1) through the ninth clock and `rw_flag` takes the direction bit.
- R4: On an address mismatch the engine sends no ACK and sets no interrupt. It then ignores the bus until the next START.
- R5: Received data bytes are assembled MSB first. A byte completed while `rx_valid`=0 is placed on `rx_data` and `rx_valid` is set. The byte is acknowledged only if the buffer was empty and `ovf` was 0.
- R6: If a byte completes while `rx_valid`=1, `ovf` is set, no ACK is sent and `rx_data` keeps the earlier byte. If `ovf`=1 but the buffer is empty, the byte is still stored but not acknowledged.
- R7: While `rx_valid`=1 and `rx_ready`=0 (and no `buf_wr`), `rx_valid` stays 1 and `rx_data` stays stable. A cycle with both high consumes the byte and clears `rx_valid`.
- R8: `irq` is set on the falling edge of the ninth SCL pulse of every byte of an addressed transfer. Only `irq_clr` clears it.
- R9: On a matching read address, the address byte is placed in the buffer (setting `rx_valid` if the buffer was empty) and `rw_flag`=1. From the ninth falling edge on, `scl_oe` holds SCL low until `rel_set` is pulsed.
- R10: `buf_wr` writes `rx_data` and also loads the transmit shifter. Transmit bits leave MSB first, and `sda_oe` changes only while SCL is low.
- R11: In transmit mode the master's acknowledge is latched on the ninth rising edge. If it is low, SCL is stretched again after the ninth falling edge. If it is high, the engine goes idle, releases both lines and waits for a START.
- R12: `ovf_clr` clears `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| own_addr | input | ADDR_W | Address this target answers to |
| buf_wr | input | 1 | Host write strobe for buffer and transmit shifter |
| buf_wdata | input | ADDR_W+1 | Byte written by the host |
| rel_set | input | 1 | Host pulse that releases a stretched SCL |
| irq_clr | input | 1 | Host pulse that clears `irq` |
| ovf_clr | input | 1 | Host pulse that clears `ovf` |
| rx_ready | input | 1 | Host accepts the buffered byte |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rx_valid | output | 1 | Buffer holds an unaccepted byte |
| rx_data | output | ADDR_W+1 | Buffer contents |
| rw_flag | output | 1 | Direction bit of the last matching address |
| irq | output | 1 | Per-byte interrupt flag |
| ovf | output | 1 | Receive overflow flag |

## Verification
The assertions watch, on every cycle, the rules that can be stated locally. `sda_oe` never moves while the synchronized SCL is high. An overflowing byte is NACKed, leaves the buffer untouched and raises `ovf`. The receive stream holds its byte under back-pressure. `irq` rises only right after an SCL falling edge. A STOP releases both lines. The bench's bus scenarios are what show address filtering, byte values in both directions, the stretch actually holding the wired SCL low until the host releases it, and the split between ACK and NACK endings of a read.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  // Byte-level link states
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_ADDR,   // shifting the address byte
    ST_RX,     // shifting a data byte from the master
    ST_ACK9,   // ninth clock, target may drive ACK
    ST_TX,     // shifting a data byte to the master
    ST_TX9     // ninth clock, master drives its acknowledge
  } link_st_e;
endpackage

// File: rtl/i2cs_bus_sampler.sv
module i2cs_bus_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic [STAGES-1:0] scl_nxt, sda_nxt;
  logic scl_p, sda_p;

  generate
    if (STAGES > 1) begin : g_multi
      assign scl_nxt = {scl_pipe[STAGES-2:0], scl_i};
      assign sda_nxt = {sda_pipe[STAGES-2:0], sda_i};
    end else begin : g_single
      assign scl_nxt = scl_i;
      assign sda_nxt = sda_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= scl_nxt;
      sda_pipe <= sda_nxt;
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s && !scl_p;
  assign scl_fall  = !scl_s && scl_p;
  // R2: bus conditions only while SCL is steadily high
  assign start_det = scl_s && scl_p && sda_p && !sda_s;
  assign stop_det  = scl_s && scl_p && !sda_p && sda_s;
endmodule

// File: rtl/i2cs_link_fsm.sv
module i2cs_link_fsm
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              buf_full,
  input  logic              ovf,
  input  logic              stretch,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  output logic              sda_oe,
  output logic              rx_evt,
  output logic              addr_evt,
  output logic              addr_rd,
  output logic [DATA_W-1:0] byte_q,
  output logic              irq_evt,
  output logic              stretch_evt
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  link_st_e          st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx_sr, tx_sr;
  logic              ack_q, tx_mode, mack_q;
  logic              quiet, addr_hit, byte_end, tx_live;

  assign quiet    = !start_det && !stop_det;
  assign addr_hit = (rx_sr[DATA_W-1:1] == own_addr);
  assign byte_end = scl_fall && (cnt == FULL);
  assign tx_live  = (st == ST_TX) && !stretch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      rx_sr   <= '0;
      tx_sr   <= '1;
      ack_q   <= 1'b0;
      tx_mode <= 1'b0;
      mack_q  <= 1'b1;
    end else begin
      // R10: host write loads the shifter unless a byte is on the wire
      if (buf_wr && !tx_live) tx_sr <= buf_wdata;
      if (start_det) begin
        st  <= ST_ADDR;
        cnt <= '0;
      end else if (stop_det) begin
        st    <= ST_IDLE;
        cnt   <= '0;
        ack_q <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise && cnt != FULL) begin
              rx_sr <= {rx_sr[DATA_W-2:0], sda_s};
              cnt   <= cnt + CNT_W'(1);
            end else if (byte_end) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (addr_hit) begin          // R3
                  st      <= ST_ACK9;
                  ack_q   <= 1'b1;
                  tx_mode <= rx_sr[0];
                end else begin
                  st <= ST_IDLE;             // R4
                end
              end else begin
                st    <= ST_ACK9;
                ack_q <= !buf_full && !ovf;  // R5, R6
              end
            end
          end
          ST_ACK9: begin
            if (scl_fall) begin
              ack_q <= 1'b0;
              st    <= tx_mode ? ST_TX : ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise && cnt != FULL) begin
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                st  <= ST_TX9;
                cnt <= '0;
              end else if (cnt != '0) begin
                tx_sr <= {tx_sr[DATA_W-2:0], 1'b1};
              end
            end
          end
          ST_TX9: begin
            if (scl_rise) mack_q <= sda_s;          // R11
            else if (scl_fall) st <= mack_q ? ST_IDLE : ST_TX;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign rx_evt      = quiet && (st == ST_RX) && byte_end;
  assign addr_evt    = quiet && (st == ST_ADDR) && byte_end && addr_hit;
  assign addr_rd     = rx_sr[0];
  assign byte_q      = rx_sr;
  assign irq_evt     = quiet && scl_fall && (st == ST_ACK9 || st == ST_TX9);
  assign stretch_evt = quiet && scl_fall &&
                       ((st == ST_ACK9 && tx_mode) || (st == ST_TX9 && !mack_q));
  assign sda_oe      = (st == ST_ACK9 && ack_q) || (st == ST_TX && !tx_sr[DATA_W-1]);

  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

  // R6
  ovf_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && buf_full) |=> !sda_oe);
endmodule

// File: rtl/i2cs_host_regs.sv
module i2cs_host_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_evt,
  input  logic              addr_evt,
  input  logic              addr_rd,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              irq_evt,
  input  logic              stretch_evt,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              rx_ready,
  input  logic              rel_set,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] buf_q,
  output logic              full_q,
  output logic              ovf_q,
  output logic              irq_q,
  output logic              rw_q,
  output logic              stretch_q
);
  logic pop, load;

  assign pop  = full_q && rx_ready;
  assign load = (rx_evt || (addr_evt && addr_rd)) && !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q     <= '0;
      full_q    <= 1'b0;
      ovf_q     <= 1'b0;
      irq_q     <= 1'b0;
      rw_q      <= 1'b0;
      stretch_q <= 1'b0;
    end else begin
      if (buf_wr)    buf_q <= buf_wdata;
      else if (load) buf_q <= byte_i;

      if (load)     full_q <= 1'b1;   // R5, R9
      else if (pop) full_q <= 1'b0;   // R7

      if (rx_evt && full_q) ovf_q <= 1'b1;   // R6
      else if (ovf_clr)     ovf_q <= 1'b0;   // R12

      if (irq_evt)      irq_q <= 1'b1;       // R8
      else if (irq_clr) irq_q <= 1'b0;

      if (addr_evt) rw_q <= addr_rd;         // R3

      if (start_det || stop_det) stretch_q <= 1'b0;  // R2
      else if (stretch_evt)      stretch_q <= 1'b1;  // R9, R11
      else if (rel_set)          stretch_q <= 1'b0;
    end
  end

  // R6
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && full_q && !buf_wr && !rx_ready) |=> (ovf_q && full_q && $stable(buf_q)));

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !rx_ready && !buf_wr) |=> (full_q && $stable(buf_q)));
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              buf_wr,
  input  logic [ADDR_W:0]   buf_wdata,
  input  logic              rel_set,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  input  logic              rx_ready,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              rx_valid,
  output logic [ADDR_W:0]   rx_data,
  output logic              rw_flag,
  output logic              irq,
  output logic              ovf
);
  localparam int DATA_W = ADDR_W + 1;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic rx_evt, addr_evt, addr_rd, irq_evt, stretch_evt;
  logic [DATA_W-1:0] byte_q;

  i2cs_bus_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cs_link_fsm #(.DATA_W(DATA_W)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .own_addr(own_addr),
    .buf_full(rx_valid), .ovf(ovf), .stretch(scl_oe),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .sda_oe(sda_oe),
    .rx_evt(rx_evt), .addr_evt(addr_evt), .addr_rd(addr_rd), .byte_q(byte_q),
    .irq_evt(irq_evt), .stretch_evt(stretch_evt)
  );

  i2cs_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .addr_evt(addr_evt),
    .addr_rd(addr_rd), .byte_i(byte_q), .irq_evt(irq_evt),
    .stretch_evt(stretch_evt), .start_det(start_det), .stop_det(stop_det),
    .buf_wr(buf_wr), .buf_wdata(buf_wdata), .rx_ready(rx_ready),
    .rel_set(rel_set), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
    .buf_q(rx_data), .full_q(rx_valid), .ovf_q(ovf), .irq_q(irq),
    .rw_q(rw_flag), .stretch_q(scl_oe)
  );

  // R8
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(scl_fall));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!scl_oe && !sda_oe));
endmodule

// File: tb/i2c_slave_engine_bench.sv
module i2c_slave_engine_bench;
  localparam int AW = 7;
  localparam int H  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_line, sda_line;
  logic [AW-1:0] own_addr = 7'h42;
  logic buf_wr = 1'b0, rel_set = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0, rx_ready = 1'b0;
  logic [AW:0] buf_wdata = '0;
  logic scl_oe, sda_oe, rx_valid, rw_flag, irq, ovf;
  logic [AW:0] rx_data;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2c_slave_engine u_i2c_slave_engine (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .own_addr(own_addr), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .rel_set(rel_set), .irq_clr(irq_clr), .ovf_clr(ovf_clr), .rx_ready(rx_ready),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
    .rw_flag(rw_flag), .irq(irq), .ovf(ovf)
  );

  int n_chk = 0, n_fail = 0;
  logic [AW:0] exp_q[$];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Scoreboard monitor: every accepted byte is compared with the queue head
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_q.size() == 0) chk("R7 unexpected byte accepted", rx_data, 0);
      else chk("R5 accepted byte", rx_data, exp_q.pop_front());
    end
  end

  task automatic bus_start();
    sda_m = 1; scl_m = 1; tick(H);
    sda_m = 0; tick(H);
    scl_m = 0; tick(H);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(H);
    scl_m = 1; tick(H);
    sda_m = 1; tick(H);
  endtask

  task automatic bit_xfer(input logic b, output logic r, output logic same);
    sda_m = b; tick(H);
    scl_m = 1;
    while (!scl_line) tick(1);
    tick(2);
    r = sda_line;
    tick(H - 4);
    same = (sda_line == r);
    scl_m = 0; tick(H);
  endtask

  task automatic byte_out(input logic [AW:0] d, output logic ack);
    logic r, s;
    for (int i = AW; i >= 0; i--) bit_xfer(d[i], r, s);
    bit_xfer(1'b1, ack, s);
  endtask

  task automatic byte_in(output logic [AW:0] d, input logic mack, output logic stab);
    logic r, s;
    stab = 1'b1;
    for (int i = AW; i >= 0; i--) begin
      bit_xfer(1'b1, r, s);
      d[i] = r;
      stab = stab & s;
    end
    bit_xfer(mack, r, s);
  endtask

  task automatic host_pop();   rx_ready = 1; tick(1); rx_ready = 0; tick(1); endtask
  task automatic host_irqclr(); irq_clr = 1; tick(1); irq_clr = 0; tick(1); endtask
  task automatic host_ovfclr(); ovf_clr = 1; tick(1); ovf_clr = 0; tick(1); endtask
  task automatic host_release(); rel_set = 1; tick(1); rel_set = 0; tick(1); endtask
  task automatic host_write(input logic [AW:0] d);
    buf_wdata = d; buf_wr = 1; tick(1); buf_wr = 0; tick(1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic ack, stab;
    logic [AW:0] d;
    tick(5);
    rst_n = 1;
    tick(3);
    // R1
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 irq/ovf/rw", {irq, ovf, rw_flag}, 0);

    // R3 write address
    bus_start();
    byte_out({7'h42, 1'b0}, ack);
    chk("R3 address ACK", ack, 0);
    chk("R3 rw_flag write", rw_flag, 0);
    chk("R8 irq after address", irq, 1);
    tick(10);
    chk("R8 irq holds until cleared", irq, 1);
    host_irqclr();
    chk("R8 irq cleared", irq, 0);

    // R5 plain receive
    exp_q.push_back(8'hA5);
    byte_out(8'hA5, ack);
    chk("R5 data ACK", ack, 0);
    chk("R5 rx_valid", rx_valid, 1);
    chk("R8 irq per byte", irq, 1);
    host_pop();
    chk("R7 rx_valid cleared by handshake", rx_valid, 0);
    host_irqclr();

    // R6 overflow
    exp_q.push_back(8'h3C);
    byte_out(8'h3C, ack);
    chk("R5 ACK into empty buffer", ack, 0);
    byte_out(8'h81, ack);
    chk("R6 NACK on full buffer", ack, 1);
    chk("R6 ovf set", ovf, 1);
    chk("R6 buffer unchanged", rx_data, 8'h3C);
    chk("R7 rx_valid held", rx_valid, 1);
    host_pop();
    exp_q.push_back(8'h57);
    byte_out(8'h57, ack);
    chk("R6 NACK while ovf set", ack, 1);
    chk("R6 stored while ovf set", rx_valid, 1);
    host_pop();
    host_ovfclr();
    chk("R12 ovf cleared", ovf, 0);
    exp_q.push_back(8'h99);
    byte_out(8'h99, ack);
    chk("R5 ACK after ovf cleared", ack, 0);
    host_pop();
    host_irqclr();

    // R2 STOP mid-byte
    for (int i = 0; i < 4; i++) bit_xfer(1'b1, ack, stab);
    bus_stop();
    chk("R2 sda released", sda_oe, 0);
    chk("R2 scl released", scl_oe, 0);
    byte_out({7'h42, 1'b0}, ack);
    chk("R2 no ACK without START", ack, 1);
    chk("R2 no irq without START", irq, 0);

    // R4 mismatch
    bus_start();
    byte_out({7'h13, 1'b0}, ack);
    chk("R4 mismatch NACK", ack, 1);
    chk("R4 mismatch no irq", irq, 0);
    byte_out(8'h66, ack);
    chk("R4 data ignored NACK", ack, 1);
    chk("R4 data ignored rx_valid", rx_valid, 0);
    bus_stop();

    // R9 read address and stretch
    bus_start();
    exp_q.push_back(8'h85);
    byte_out({7'h42, 1'b1}, ack);
    chk("R3 read address ACK", ack, 0);
    chk("R9 rw_flag read", rw_flag, 1);
    chk("R9 address in buffer", rx_data, 8'h85);
    chk("R8 irq read address", irq, 1);
    scl_m = 1; tick(20);
    chk("R9 SCL held low", scl_line, 0);
    scl_m = 0; tick(2);
    host_pop();
    host_irqclr();
    host_write(8'hC6);
    host_release();
    byte_in(d, 1'b0, stab);
    chk("R10 transmit byte", d, 8'hC6);
    chk("R10 SDA stable while SCL high", stab, 1);
    chk("R8 irq after transmit", irq, 1);
    chk("R11 restretch after ACK", scl_oe, 1);
    host_irqclr();
    host_write(8'h1F);
    host_release();
    byte_in(d, 1'b1, stab);
    chk("R10 second transmit byte", d, 8'h1F);
    chk("R10 second byte SDA stable", stab, 1);
    chk("R11 NACK releases SCL", scl_oe, 0);
    chk("R11 NACK releases SDA", sda_oe, 0);
    byte_in(d, 1'b1, stab);
    chk("R11 idle after NACK", d, 8'hFF);
    bus_stop();
    chk("R7 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule